// File: doc/BRIEF.md
# UART Modem Status Register

This block is the modem status register of a serial port. It watches four active-low modem lines: carrier detect, ring indicator, data set ready and clear to send. Each line passes through a synchronizer. The block then presents the true (inverted) line levels in the upper half of an 8-bit status word. In loopback mode the upper half shows four modem-control bits instead, using a fixed cross-mapping. The lower half holds sticky change flags, and a read of the register clears them.

Change detection runs on the value after the loopback selection. In loopback mode the flags therefore follow the looped control bits, and entering or leaving loopback can itself raise flags. The ring flag is set only when the ring line goes from high to low. The other three flags are set on any change of their line. A modem-status interrupt request is raised while any flag is set and the interrupt enable is high.

Top module: `uart_modem_status`

## Requirements
- R1: After synchronous reset the status word reads 0x00 and the interrupt request is low, provided all four lines are held high.
- R2: In normal mode the upper bits are the inverted, synchronized line levels: bit 7 carrier detect, bit 6 ring, bit 5 data set ready, bit 4 clear to send.
- R3: In loopback mode bit 7 equals control bit 3, bit 6 equals control bit 2, bit 5 equals control bit 0 and bit 4 equals control bit 1.
- R4: Flag bits 3, 1 and 0 are set when the carrier detect, data set ready and clear to send level changes, in either direction.
- R5: Flag bit 2 is set only when the ring line falls from high to low. A rise leaves it unchanged.
- R6: A read (read strobe high for one cycle) returns the flags as they were, and clears all four flags at the next clock edge.
- R7: If a change event and a read fall in the same cycle, the read returns the flag as it was before the event, and the flag remains set afterwards.
- R8: In loopback mode the line inputs have no effect on the status word or the flags. Changes of the looped control bits, and changes caused by switching the mode, raise flags as the rules of R4 and R5 state.
- R9: The interrupt request is high exactly when the interrupt enable is high and at least one of flag bits 3 to 0 is set.
- R10: A line change shows in the status word two clock edges after it is sampled. The flag is set one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| n_dcd | input | 1 | Carrier detect line, active low, asynchronous |
| n_ri | input | 1 | Ring indicator line, active low, asynchronous |
| n_dsr | input | 1 | Data set ready line, active low, asynchronous |
| n_cts | input | 1 | Clear to send line, active low, asynchronous |
| loop_en | input | 1 | Loopback mode select |
| mctl | input | 4 | Modem control bits: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2 |
| rd_stb | input | 1 | Status register read strobe |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status word: line levels in bits 7..4, flags in bits 3..0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a read that lands in the same cycle as the edge that sets a flag. The line change first has to clear the synchronizer, so the bench changes a line and counts exactly two rising edges before it raises the read strobe. That read must return the flag clear while the upper bits already show the new level, and a second read must find the flag set. The mode-switch flags are reached by choosing control bits whose looped levels differ from the held line levels before loopback is entered or left.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int LINES = 4;

    // line vector order (index = status bit - 4)
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // modem control bit positions
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;

    // lines whose flag fires on a high-to-low transition only
    localparam logic [LINES-1:0] FALL_ONLY_MASK = 4'b0100;

    typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int   WIDTH   = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= {WIDTH{RST_VAL}};
            end
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/msr_flags.sv
module msr_flags #(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] FALL_ONLY = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    input  logic             rd_clr,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] evt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (FALL_ONLY[i]) begin : g_fall
            assign evt[i] = prev_q[i] & ~lvl[i];
        end else begin : g_any
            assign evt[i] = prev_q[i] ^ lvl[i];
        end

        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (evt[i]) flags[i] <= 1'b1;
            else if (rd_clr) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       n_dcd,
    input  logic       n_ri,
    input  logic       n_dsr,
    input  logic       n_cts,
    input  logic       loop_en,
    input  logic [3:0] mctl,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] rd_data,
    output logic       irq
);
    line_vec_t pin_raw;
    line_vec_t pin_sync;
    line_vec_t loop_lvl;
    line_vec_t line_lvl;
    line_vec_t flags;

    always_comb begin
        pin_raw         = '0;
        pin_raw[LN_DCD] = n_dcd;
        pin_raw[LN_RI]  = n_ri;
        pin_raw[LN_DSR] = n_dsr;
        pin_raw[LN_CTS] = n_cts;
    end

    msr_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_raw),
        .q  (pin_sync)
    );

    // looped control bits expressed as equivalent active-low line levels
    always_comb begin
        loop_lvl         = '0;
        loop_lvl[LN_DCD] = ~mctl[MC_OUT2];
        loop_lvl[LN_RI]  = ~mctl[MC_OUT1];
        loop_lvl[LN_DSR] = ~mctl[MC_DTR];
        loop_lvl[LN_CTS] = ~mctl[MC_RTS];
    end

    assign line_lvl = loop_en ? loop_lvl : pin_sync;

    msr_flags #(
        .WIDTH    (LINES),
        .FALL_ONLY(FALL_ONLY_MASK)
    ) u_flags (
        .clk   (clk),
        .rst   (rst),
        .lvl   (line_lvl),
        .rd_clr(rd_stb),
        .flags (flags)
    );

    assign rd_data = {~line_lvl, flags};
    assign irq     = irq_en & (|flags);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
    input logic       clk,
    input logic       rst,
    input logic       n_dcd,
    input logic       n_ri,
    input logic       n_dsr,
    input logic       n_cts,
    input logic       loop_en,
    input logic [3:0] mctl,
    input logic       rd_stb,
    input logic       irq_en,
    input logic [7:0] rd_data,
    input logic       irq
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)              age_q <= 2'd0;
        else if (age_q != 3)  age_q <= age_q + 2'd1;
    end

    // R9
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_en && (rd_data[3:0] != 4'd0)));

    // R3
    assert_loop_map_R3: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> rd_data[7:4] == {mctl[3], mctl[2], mctl[0], mctl[1]});

    // R10 / R2
    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3 && !loop_en) |->
            rd_data[7:4] == ~{$past(n_dcd, 2), $past(n_ri, 2), $past(n_dsr, 2), $past(n_cts, 2)});

    // R6
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3 && $past(rd_stb) && $past(rd_data[7:4]) == $past(rd_data[7:4], 2))
            |-> rd_data[3:0] == 4'd0);

    // R4
    assert_dcd_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3 && $past(rd_data[7]) != $past(rd_data[7], 2)) |-> rd_data[3]);

    assert_cts_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3 && $past(rd_data[4]) != $past(rd_data[4], 2)) |-> rd_data[0]);

    // R5
    assert_ring_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3 && !$past(rd_data[6], 2) && $past(rd_data[6])) |-> rd_data[2]);

    assert_ring_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3 && $past(rd_data[6], 2) && !$past(rd_data[6]) && !$past(rd_data[2]))
            |-> !rd_data[2]);
endmodule

bind uart_modem_status msr_checker u_msr_checker (
    .clk    (clk),
    .rst    (rst),
    .n_dcd  (n_dcd),
    .n_ri   (n_ri),
    .n_dsr  (n_dsr),
    .n_cts  (n_cts),
    .loop_en(loop_en),
    .mctl   (mctl),
    .rd_stb (rd_stb),
    .irq_en (irq_en),
    .rd_data(rd_data),
    .irq    (irq)
);

// File: tb/tb_uart_modem_status.sv
module tb_uart_modem_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       n_dcd = 1'b1, n_ri = 1'b1, n_dsr = 1'b1, n_cts = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] mctl = 4'd0;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_modem_status dut (
        .clk(clk), .rst(rst),
        .n_dcd(n_dcd), .n_ri(n_ri), .n_dsr(n_dsr), .n_cts(n_cts),
        .loop_en(loop_en), .mctl(mctl),
        .rd_stb(rd_stb), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];
    event  smp;

    // model state: pins as {dcd, ri, dsr, cts}
    logic [3:0] m_pins = 4'hF;
    logic       m_loop = 1'b0;
    logic [3:0] m_mctl = 4'h0;
    logic [3:0] m_flags = 4'h0;

    function automatic logic [3:0] eff(input logic [3:0] p, input logic l, input logic [3:0] m);
        return l ? ~{m[3], m[2], m[0], m[1]} : p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops an expected item at each read sample
    always @(smp) begin
        item_t it;
        if (sb_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", rd_data, 8'h00);
        end else begin
            it = sb_q.pop_front();
            check(rd_data === it.exp, it.tag, rd_data, it.exp);
        end
    end

    task automatic drive(input logic [3:0] np, input logic nl, input logic [3:0] nm);
        logic [3:0] o, n;
        o = eff(m_pins, m_loop, m_mctl);
        n = eff(np, nl, nm);
        m_flags |= ((o ^ n) & 4'b1011) | (o & ~n & 4'b0100);
        m_pins = np; m_loop = nl; m_mctl = nm;
        @(negedge clk);
        {n_dcd, n_ri, n_dsr, n_cts} = np;
        loop_en = nl;
        mctl = nm;
    endtask

    task automatic apply(input logic [3:0] np, input logic nl, input logic [3:0] nm);
        drive(np, nl, nm);
        repeat (3) @(posedge clk);
    endtask

    task automatic push_read(input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        rd_stb = 1'b1;
        #2;
        -> smp;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_read(input string tag);
        logic [7:0] e;
        e = {~eff(m_pins, m_loop, m_mctl), m_flags};
        m_flags = 4'h0;
        push_read(e, tag);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%02h expected=%02h", rd_data, 8'h00);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(irq === 1'b0, "R1 irq after reset", {7'd0, irq}, 8'h00);
        do_read("R1 reset status");

        // R2 R4: clear to send asserted
        irq_en = 1'b1;
        apply(4'b1110, 1'b0, 4'h0);
        @(negedge clk);
        check(irq === 1'b1, "R9 irq with flag and enable", {7'd0, irq}, 8'h01);
        do_read("R2 R4 cts asserted");
        @(negedge clk);
        check(irq === 1'b0, "R9 irq after read", {7'd0, irq}, 8'h00);
        do_read("R6 flags cleared by read");

        // R2 R4: carrier and data set ready together
        apply(4'b0100, 1'b0, 4'h0);
        do_read("R2 R4 dcd dsr asserted");

        // R5: ring fall sets, ring rise does not
        apply(4'b0000, 1'b0, 4'h0);
        do_read("R5 ring falling edge");
        apply(4'b0100, 1'b0, 4'h0);
        do_read("R5 ring rising edge no flag");

        // R4: deassert direction, with interrupt disabled
        irq_en = 1'b0;
        apply(4'b0101, 1'b0, 4'h0);
        @(negedge clk);
        check(irq === 1'b0, "R9 irq gated by enable", {7'd0, irq}, 8'h00);
        do_read("R4 cts deasserted");
        irq_en = 1'b1;

        // R10: latency of carrier detect release
        drive(4'b1101, 1'b0, 4'h0);
        @(posedge clk); @(negedge clk);
        check(rd_data[7] === 1'b1, "R10 one edge unchanged", rd_data, {1'b1, rd_data[6:0]});
        @(posedge clk); @(negedge clk);
        check(rd_data[7] === 1'b0, "R10 two edges visible", rd_data, {1'b0, rd_data[6:0]});
        check(rd_data[3] === 1'b0, "R10 flag not yet set", rd_data, {rd_data[7:4], 1'b0, rd_data[2:0]});
        @(posedge clk); @(negedge clk);
        check(rd_data[3] === 1'b1, "R10 flag after three edges", rd_data, {rd_data[7:4], 1'b1, rd_data[2:0]});
        do_read("R4 dcd deasserted");

        // R3 R8: loopback entry and control mapping
        apply(4'b1101, 1'b1, 4'b0000);
        do_read("R8 enter loopback flags");
        apply(4'b1101, 1'b1, 4'b0001);
        do_read("R3 DTR to bit5");
        apply(4'b1101, 1'b1, 4'b1000);
        do_read("R3 OUT2 to bit7");
        apply(4'b1101, 1'b1, 4'b0100);
        do_read("R3 R5 OUT1 to bit6");
        apply(4'b1101, 1'b1, 4'b0010);
        do_read("R3 RTS to bit4");

        // R8: pins ignored in loopback
        apply(4'b0010, 1'b1, 4'b0010);
        do_read("R8 pins ignored in loopback");

        // R8: leave loopback
        apply(4'b0010, 1'b0, 4'b0010);
        do_read("R8 leave loopback flags");
        do_read("R6 clear after loopback exit");

        // R7: read in the same cycle as the flag event
        begin
            logic [3:0] o, n;
            o = eff(m_pins, m_loop, m_mctl);
            drive(4'b0011, 1'b0, 4'b0010);
            n = eff(m_pins, m_loop, m_mctl);
            m_flags = 4'h0;
            repeat (2) @(posedge clk);
            push_read({~n, 4'b0000}, "R7 read returns pre-event flag");
            m_flags = ((o ^ n) & 4'b1011) | (o & ~n & 4'b0100);
            repeat (2) @(posedge clk);
            do_read("R7 flag survives colliding read");
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", 8'(sb_q.size()), 8'h00);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule